// File: doc/BRIEF.md
# Input Clock Absence Monitor

This block watches one input clock from a free-running reference clock. It raises a loss flag when the watched clock stops, and it drops the flag again soon after the clock comes back. The two timings are deliberately unequal. The flag is raised only after a long quiet interval, `TIMEOUT_CYC` reference cycles; the default of 1500 is 15 µs at 100 MHz. The flag is cleared within a few reference cycles of the returning edges. Each clock input of the chip gets its own instance.

In the watched-clock domain, a single flop toggles on every rising edge. In the reference domain, `SYNC_STAGES` flops resynchronise that toggle, and a final compare stage turns each change of level into a one-cycle activity event. A three-state machine consumes these events:

- `ST_LOST`: flag high.
- `ST_CONFIRM`: flag high while returning edges are counted.
- `ST_PRESENT`: flag low.

The transitions are:

- **lost→present** (`CLEAR_EVENTS` = 1): taken on the first event.
- **lost→confirm** (`CLEAR_EVENTS` > 1): taken on the first event.
- **confirm→present**: taken when the `CLEAR_EVENTS`-th consecutive event arrives.
- **confirm→lost**: taken when no event arrives for `GAP_CYC` cycles.
- **present→lost**: taken after `TIMEOUT_CYC` cycles without an event.

Top module: `inclk_absence_monitor`

## Requirements
- R1: While `rst_n` is low, and after its release until activity has been seen, `loss_flag` is 1.
- R2: `loss_flag` encodes 1 = watched clock absent and 0 = watched clock present. It is 1 in `ST_LOST` and `ST_CONFIRM`, and 0 only in `ST_PRESENT`.
- R3: In `ST_PRESENT`, `loss_flag` rises once `TIMEOUT_CYC` consecutive reference cycles have passed with no activity event, and not earlier.
- R4: Every rising edge of `mon_clk` produces exactly one activity event, and each event restarts the quiet count. A clock whose edges are never `TIMEOUT_CYC` cycles apart therefore keeps `loss_flag` at 0.
- R5: From `ST_LOST`, `loss_flag` falls only when `CLEAR_EVENTS` activity events have arrived, with no gap of `GAP_CYC` cycles between them. Fewer events leave it at 1.
- R6: In `ST_CONFIRM`, a gap of `GAP_CYC` cycles with no event discards the partial count and returns to `ST_LOST`. The next clear then needs a full `CLEAR_EVENTS` events again.
- R7: With `SYNC_STAGES` = 2, `loss_flag` falls within 4 reference cycles of the `mon_clk` rising edge that completes the count.
- R8: With `CLEAR_EVENTS` = 1, a single rising edge after a loss clears the flag, because the machine goes straight from lost to present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_clk | input | 1 | Watched input clock |
| loss_flag | output | 1 | 1 = watched clock absent, 0 = present |

## Verification
The bench first applies directed patterns:

- **Single edges after a loss:** show the difference between one-edge and multi-edge clearing (R5, R8).
- **A slow clock whose gaps stay under the timeout:** shows that each edge restarts the quiet count (R4).
- **A full stop:** brackets the loss point from both sides (R3).
- **Two edges, a long pause, then one edge:** shows whether the partial count was really discarded (R6).

After these, random bursts of varied period are each followed by a random quiet interval. These show the clear path and the timeout path working together. Any quiet interval that lands close to the threshold is not checked.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;

    typedef enum logic [1:0] {
        ST_LOST    = 2'd0,
        ST_CONFIRM = 2'd1,
        ST_PRESENT = 2'd2
    } mon_state_t;

endpackage

// File: rtl/mon_toggle.sv
// Toggle flop clocked by the watched clock: each rising edge flips it.
module mon_toggle (
    input  logic mon_clk,
    input  logic rst_n,
    output logic tgl
);
    always_ff @(posedge mon_clk or negedge rst_n) begin
        if (!rst_n) tgl <= 1'b0;
        else        tgl <= ~tgl;
    end
endmodule

// File: rtl/act_sync.sv
// Resynchronises the toggle into the reference domain and
// marks each change of level as a one-cycle activity event.
module act_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic tgl_async,
    output logic act_evt
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge ref_clk or negedge rst_n) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= tgl_async;
                end
            end else begin : g_next
                always_ff @(posedge ref_clk or negedge rst_n) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[SYNC_STAGES-1];
    end

    assign act_evt = sync_q[SYNC_STAGES-1] ^ last_q;
endmodule

// File: rtl/los_fsm.sv
// Three-state loss / confirm / present machine with quiet and event counters.
module los_fsm
    import clkmon_pkg::*;
#(
    parameter int TIMEOUT_CYC  = 1500,
    parameter int CLEAR_EVENTS = 1,
    parameter int GAP_CYC      = 256
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic act_evt,
    output logic loss_flag
);
    localparam int IDLE_MAX = (TIMEOUT_CYC > GAP_CYC) ? TIMEOUT_CYC : GAP_CYC;
    localparam int IDW      = $clog2(IDLE_MAX + 1);
    localparam int EVW      = $clog2(CLEAR_EVENTS + 1);
    localparam logic [IDW-1:0] IDLE_SAT = IDW'(IDLE_MAX);
    localparam logic [IDW-1:0] TO_LAST  = IDW'(TIMEOUT_CYC - 1);
    localparam logic [IDW-1:0] GAP_LAST = IDW'(GAP_CYC - 1);
    localparam logic [EVW-1:0] EV_LAST  = EVW'(CLEAR_EVENTS - 1);

    mon_state_t     state_q, state_nx;
    logic [IDW-1:0] idle_q;
    logic [EVW-1:0] ev_q;

    // state register
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOST;
        else        state_q <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_LOST: begin
                if (act_evt)
                    state_nx = (CLEAR_EVENTS == 1) ? ST_PRESENT : ST_CONFIRM;
            end
            ST_CONFIRM: begin
                if (act_evt && ev_q == EV_LAST)
                    state_nx = ST_PRESENT;
                else if (!act_evt && idle_q == GAP_LAST)
                    state_nx = ST_LOST;
            end
            ST_PRESENT: begin
                if (!act_evt && idle_q == TO_LAST)
                    state_nx = ST_LOST;
            end
            default: state_nx = ST_LOST;
        endcase
    end

    // quiet-cycle and event counters
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_q <= '0;
            ev_q   <= '0;
        end else begin
            if (act_evt)             idle_q <= '0;
            else if (idle_q != IDLE_SAT) idle_q <= idle_q + 1'b1;

            if (state_nx != ST_CONFIRM)  ev_q <= '0;
            else if (act_evt)            ev_q <= ev_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        loss_flag = (state_q != ST_PRESENT);
    end
endmodule

// File: rtl/inclk_absence_monitor.sv
module inclk_absence_monitor #(
    parameter int TIMEOUT_CYC  = 1500,
    parameter int CLEAR_EVENTS = 1,
    parameter int GAP_CYC      = 256,
    parameter int SYNC_STAGES  = 2
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic mon_clk,
    output logic loss_flag
);
    logic tgl;
    logic act_evt;

    mon_toggle u_tgl (
        .mon_clk (mon_clk),
        .rst_n   (rst_n),
        .tgl     (tgl)
    );

    act_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .ref_clk   (ref_clk),
        .rst_n     (rst_n),
        .tgl_async (tgl),
        .act_evt   (act_evt)
    );

    los_fsm #(
        .TIMEOUT_CYC  (TIMEOUT_CYC),
        .CLEAR_EVENTS (CLEAR_EVENTS),
        .GAP_CYC      (GAP_CYC)
    ) u_fsm (
        .ref_clk   (ref_clk),
        .rst_n     (rst_n),
        .act_evt   (act_evt),
        .loss_flag (loss_flag)
    );
endmodule

// File: rtl/inclk_absence_monitor_chk.sv
module inclk_absence_monitor_chk #(
    parameter int TIMEOUT_CYC = 1500
) (
    input logic ref_clk,
    input logic rst_n,
    input logic act_evt,
    input logic loss_flag
);
    localparam int QW = $clog2(TIMEOUT_CYC + 2);
    localparam logic [QW-1:0] Q_SAT = QW'(TIMEOUT_CYC + 1);

    logic [QW-1:0] quiet_q;
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n)               quiet_q <= '0;
        else if (act_evt)         quiet_q <= '0;
        else if (quiet_q != Q_SAT) quiet_q <= quiet_q + 1'b1;
    end

    // R1
    reset_flag_chk: assert property (@(posedge ref_clk)
        !rst_n |=> loss_flag);

    // R3
    loss_after_quiet_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(loss_flag) |-> (quiet_q >= QW'(TIMEOUT_CYC)));

    // R4
    activity_keeps_clear_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (!loss_flag && act_evt) |=> !loss_flag);

    // R5
    clear_on_event_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $fell(loss_flag) |-> $past(act_evt));
endmodule

bind inclk_absence_monitor inclk_absence_monitor_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
    .ref_clk   (ref_clk),
    .rst_n     (rst_n),
    .act_evt   (act_evt),
    .loss_flag (loss_flag)
);

// File: tb/test_inclk_absence_monitor.sv
`timescale 1ns/1ps
module test_inclk_absence_monitor;
    localparam int TO  = 60;
    localparam int NEV = 3;
    localparam int GAP = 20;

    logic ref_clk = 1'b0;
    logic rst_n   = 1'b0;
    logic mon_clk = 1'b0;
    logic flag_m, flag_s;
    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;

    always #2.5 ref_clk = ~ref_clk;

    inclk_absence_monitor #(.TIMEOUT_CYC(TO), .CLEAR_EVENTS(NEV), .GAP_CYC(GAP)) i_inclk_absence_monitor (
        .ref_clk(ref_clk), .rst_n(rst_n), .mon_clk(mon_clk), .loss_flag(flag_m));

    inclk_absence_monitor #(.TIMEOUT_CYC(TO), .CLEAR_EVENTS(1), .GAP_CYC(GAP)) i_inclk_absence_monitor_one (
        .ref_clk(ref_clk), .rst_n(rst_n), .mon_clk(mon_clk), .loss_flag(flag_s));

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge ref_clk);
    endtask

    task automatic pulse(input int half);
        mon_clk = 1'b1; #(half);
        mon_clk = 1'b0; #(half);
    endtask

    // expected flag after a quiet interval; 2 = too close to the threshold to judge
    function automatic int exp_after_idle(input int idle);
        if (idle <= TO - 8) return 0;
        if (idle >= TO + 8) return 1;
        return 2;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge ref_clk);
        errors++;
        $display("FAIL watchdog: got hang expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        cyc(10);
        chk("R1 in reset", flag_m, 1'b1);
        rst_n = 1'b1;
        cyc(100);
        chk("R1 after reset idle", flag_m, 1'b1);
        chk("R2 absent encoding", flag_s, 1'b1);

        // one edge: single-event instance clears, three-event one does not
        pulse(10); cyc(5);
        chk("R8 single edge clears", flag_s, 1'b0);
        chk("R5 one of three", flag_m, 1'b1);
        pulse(10); cyc(5);
        chk("R5 two of three", flag_m, 1'b1);
        mon_clk = 1'b1; cyc(5);
        chk("R7 clear latency", flag_m, 1'b0);
        chk("R2 present encoding", flag_m, 1'b0);
        mon_clk = 1'b0; cyc(2);

        // slow clock, gaps below timeout
        for (int i = 0; i < 6; i++) begin
            cyc(45); pulse(10);
            chk("R4 slow clock stays present", flag_m, 1'b0);
        end

        // full stop
        cyc(TO - 8);
        chk("R3 not before timeout", flag_m, 1'b0);
        cyc(16);
        chk("R3 after timeout", flag_m, 1'b1);
        chk("R3 single instance", flag_s, 1'b1);

        // partial count discarded by a long gap
        pulse(10); pulse(10);
        cyc(GAP + 10);
        pulse(10); cyc(5);
        chk("R6 count restarted", flag_m, 1'b1);
        pulse(10); pulse(10); cyc(5);
        chk("R6 full recount clears", flag_m, 1'b0);

        // random bursts and quiet intervals
        for (int it = 0; it < 40; it++) begin
            int k, half, l, e;
            k    = 3 + int'($urandom % 4);
            half = 8 + int'($urandom % 20);
            l    = int'($urandom % 130);
            for (int p = 0; p < k; p++) pulse(half);
            cyc(6);
            chk("R5 random burst clears", flag_m, 1'b0);
            cyc(l);
            e = exp_after_idle(l + 6 + half / 5);
            if (e != 2) chk("R3 random quiet", flag_m, e[0]);
        end

        finish_run();
    end
endmodule